// File: doc/BRIEF.md
# Page-Crossing Buffer Address Generator

This block walks a transfer buffer that is spread over a short, ordered list of 4 KiB physical pages and produces one bus beat per clock: the physical byte address of the beat and the number of bytes it carries. The caller supplies the list of page pointers, a page index and a byte offset at which to begin, and a byte count. The first beat begins at the given offset inside the given page. When the running offset reaches the end of a page, the next beat is formed from the upper bits of the next pointer in the list with an in-page offset of zero. Every later page is therefore entered at its top. A beat never spans two pages. A beat that would reach past a page end is cut short there.

The pointer list is captured when a transfer starts, so the caller may reuse its inputs while the walk is in progress. At the end of a transfer the block reports the page index and offset of the first byte not yet moved. A later transfer can resume from that point by passing these values back as its start position. An empty request finishes at once. A request that would need a page beyond the last list entry is refused with an error pulse and produces no beats.

The controller has four states. IDLE waits for `start`. RUN emits one beat per cycle. DONE is a one-cycle completion pulse. FAULT is a one-cycle refusal pulse. The transitions are as follows:
- IDLE goes to RUN on a start with a nonzero length that fits the list.
- IDLE goes to DONE on a start with zero length.
- IDLE goes to FAULT on a start that needs too many pages.
- RUN goes to DONE on the beat that consumes the last byte.
- DONE and FAULT return to IDLE after one cycle.

Top module: `pgx_addr_gen`

## Requirements
- R1: After reset the block is in IDLE: `beat_valid`, `done` and `err` are 0, and `bytes_left`, `cur_idx` and `cur_off` are 0.
- R2: `start` is acted on only in IDLE. A `start` pulse, new start values or new pointer values applied during RUN do not change the remaining beats, which keep using the pointers captured when the transfer began.
- R3: `beat_addr` is bits 31..12 of the pointer at the current page index, followed by the current 12-bit in-page offset. Bits 11..0 of every pointer are ignored.
- R4: The first beat appears in the cycle after `start` is sampled. It is addressed at `start_off` inside the page selected by `start_idx`.
- R5: `beat_bytes` equals the smallest of BEAT_BYTES (default 8), the bytes still remaining, and the bytes from the current offset to the end of the 4 KiB page. No beat crosses a 4 KiB boundary.
- R6: After a beat that ends exactly on a page end, the next beat uses the next list entry (index + 1) at offset 0. Pages are visited strictly in list order.
- R7: `bytes_left` shows the bytes remaining before the current beat. It falls by `beat_bytes` after each beat.
- R8: In the cycle after the last beat, `done` is 1 for exactly one cycle, `bytes_left` is 0, and `cur_idx`/`cur_off` give the position just past the last byte. If the transfer ended exactly on a page end, this is index + 1 with offset 0.
- R9: A start with `xfer_len` = 0 produces no beat and raises `done` in the cycle after `start`.
- R10: If `start_idx` + (number of pages from `start_off` to the last byte) exceeds 5, `err` is 1 for one cycle after `start` and no beat is produced. A transfer that fits exactly in entry 4 is accepted.
- R11: A nonzero `start_idx` resumes the walk mid-list. The first beat uses that entry at `start_off`.
- R12: During RUN, `beat_valid` is 1 on every consecutive cycle until the last beat, and `beat_valid`, `done` and `err` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled in IDLE only) |
| page_ptrs | input | NUM_PAGES*ADDR_W (160) | Page pointer list; entry k occupies bits [k*32 +: 32] |
| start_idx | input | IDX_W (3) | Page list index of the first byte |
| start_off | input | PAGE_BITS (12) | Byte offset of the first byte within its page |
| xfer_len | input | LEN_W (16) | Transfer length in bytes |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_addr | output | ADDR_W (32) | Physical byte address of the beat |
| beat_bytes | output | BL_W (4) | Bytes carried by the beat |
| bytes_left | output | LEN_W (16) | Bytes remaining before this beat |
| cur_idx | output | IDX_W (3) | Current page index (resume point after DONE) |
| cur_off | output | PAGE_BITS (12) | Current in-page offset (resume point after DONE) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse when a request needs a page past the list |

## Verification
The position registers that drive the address are checked in every beat cycle. A wrong offset or page index therefore shows on `beat_addr` in the very beat that uses it. A missed page advance gives an address below the page top on the same cycle. A byte-count error in the remaining-length register shows on `bytes_left` and `beat_bytes` at once. Because the walk runs on a fixed beat schedule, the same error also moves the `done` pulse one or more cycles away from where the bench model expects it. The resume position is compared at the `done` cycle. An error that only appears at a page end therefore surfaces no later than the end of that transfer.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } pgx_state_e;

endpackage

// File: rtl/pgx_frame_mux.sv
module pgx_frame_mux #(
    parameter int NUM_PAGES = 5,
    parameter int FRAME_W   = 20,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_PAGES*FRAME_W-1:0] frames_flat,
    input  logic [IDX_W-1:0]             sel,
    output logic [FRAME_W-1:0]           frame
);

    logic [FRAME_W-1:0] frames [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_unpack
        assign frames[g] = frames_flat[g*FRAME_W +: FRAME_W];
    end

    always_comb begin
        frame = '0;
        for (int k = 0; k < NUM_PAGES; k++) begin
            if (IDX_W'(k) == sel) frame = frames[k];
        end
    end

endmodule

// File: rtl/pgx_beat_sizer.sv
module pgx_beat_sizer #(
    parameter int PAGE_BITS  = 12,
    parameter int LEN_W      = 16,
    parameter int BEAT_BYTES = 8,
    parameter int BL_W       = 4
) (
    input  logic [PAGE_BITS-1:0] off,
    input  logic [LEN_W-1:0]     rem,
    output logic [BL_W-1:0]      len
);

    localparam int CW        = LEN_W + 1;
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    logic [CW-1:0] room;
    logic [CW-1:0] cand;

    always_comb begin
        room = CW'(PAGE_SIZE) - CW'(off);
        cand = CW'(BEAT_BYTES);
        if (CW'(rem) < cand) cand = CW'(rem);
        if (room < cand)     cand = room;
        len = cand[BL_W-1:0];
    end

endmodule

// File: rtl/pgx_span_check.sv
module pgx_span_check #(
    parameter int NUM_PAGES = 5,
    parameter int PAGE_BITS = 12,
    parameter int LEN_W     = 16,
    parameter int IDX_W     = 3
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic [PAGE_BITS-1:0] off,
    input  logic [LEN_W-1:0]     len,
    output logic                 empty,
    output logic                 too_many
);

    localparam int CW = LEN_W + 1;
    localparam int TW = CW + 1;

    logic [CW-1:0] last_byte;
    logic [CW-1:0] page_span;
    logic [TW-1:0] end_entry;

    assign empty     = (len == '0);
    assign last_byte = CW'(off) + CW'(len) - CW'(1);
    assign page_span = last_byte >> PAGE_BITS;
    assign end_entry = TW'(idx) + TW'(page_span) + TW'(1);
    assign too_many  = !empty && (end_entry > TW'(NUM_PAGES));

endmodule

// File: rtl/pgx_addr_gen.sv
module pgx_addr_gen
    import pgx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BITS  = 12,
    parameter int NUM_PAGES  = 5,
    parameter int BEAT_BYTES = 8,
    parameter int LEN_W      = 16,
    parameter int IDX_W      = $clog2(NUM_PAGES + 1),
    parameter int BL_W       = $clog2(BEAT_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NUM_PAGES*ADDR_W-1:0] page_ptrs,
    input  logic [IDX_W-1:0]            start_idx,
    input  logic [PAGE_BITS-1:0]        start_off,
    input  logic [LEN_W-1:0]            xfer_len,
    output logic                        beat_valid,
    output logic [ADDR_W-1:0]           beat_addr,
    output logic [BL_W-1:0]             beat_bytes,
    output logic [LEN_W-1:0]            bytes_left,
    output logic [IDX_W-1:0]            cur_idx,
    output logic [PAGE_BITS-1:0]        cur_off,
    output logic                        done,
    output logic                        err
);

    localparam int FRAME_W   = ADDR_W - PAGE_BITS;
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    pgx_state_e state_q, state_d;

    logic [IDX_W-1:0]             idx_q;
    logic [PAGE_BITS-1:0]         off_q;
    logic [LEN_W-1:0]             rem_q;
    logic [NUM_PAGES*FRAME_W-1:0] frames_q;

    logic [NUM_PAGES*FRAME_W-1:0]   frames_in;
    logic [NUM_PAGES*PAGE_BITS-1:0] low_in;
    logic                           unused_low;

    logic [FRAME_W-1:0]   frame_sel;
    logic [BL_W-1:0]      beat_len;
    logic [PAGE_BITS:0]   off_sum;
    logic                 page_wrap;
    logic                 req_empty;
    logic                 req_too_many;
    logic                 accept;
    logic                 last_beat;

    // Split every pointer into its frame bits and the ignored in-page bits
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_split
        assign frames_in[g*FRAME_W +: FRAME_W]   = page_ptrs[g*ADDR_W + PAGE_BITS +: FRAME_W];
        assign low_in[g*PAGE_BITS +: PAGE_BITS]  = page_ptrs[g*ADDR_W +: PAGE_BITS];
    end
    assign unused_low = ^low_in;

    pgx_frame_mux #(
        .NUM_PAGES (NUM_PAGES),
        .FRAME_W   (FRAME_W),
        .IDX_W     (IDX_W)
    ) u_mux (
        .frames_flat (frames_q),
        .sel         (idx_q),
        .frame       (frame_sel)
    );

    pgx_beat_sizer #(
        .PAGE_BITS  (PAGE_BITS),
        .LEN_W      (LEN_W),
        .BEAT_BYTES (BEAT_BYTES),
        .BL_W       (BL_W)
    ) u_sizer (
        .off (off_q),
        .rem (rem_q),
        .len (beat_len)
    );

    pgx_span_check #(
        .NUM_PAGES (NUM_PAGES),
        .PAGE_BITS (PAGE_BITS),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W)
    ) u_span (
        .idx      (start_idx),
        .off      (start_off),
        .len      (xfer_len),
        .empty    (req_empty),
        .too_many (req_too_many)
    );

    assign accept    = (state_q == ST_IDLE) && start;
    assign off_sum   = {1'b0, off_q} + (PAGE_BITS+1)'(beat_len);
    assign page_wrap = off_sum[PAGE_BITS];
    assign last_beat = (rem_q == LEN_W'(beat_len));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (req_empty)         state_d = ST_DONE;
                    else if (req_too_many) state_d = ST_FAULT;
                    else                   state_d = ST_RUN;
                end
            end
            ST_RUN:   if (last_beat) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Position, length and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            off_q    <= '0;
            rem_q    <= '0;
            frames_q <= '0;
        end else if (accept) begin
            idx_q    <= start_idx;
            off_q    <= start_off;
            rem_q    <= xfer_len;
            frames_q <= frames_in;
        end else if (state_q == ST_RUN) begin
            rem_q <= rem_q - LEN_W'(beat_len);
            if (page_wrap) begin
                off_q <= '0;
                idx_q <= idx_q + IDX_W'(1);
            end else begin
                off_q <= off_sum[PAGE_BITS-1:0];
            end
        end
    end

    // Outputs
    always_comb begin
        beat_valid = (state_q == ST_RUN);
        done       = (state_q == ST_DONE);
        err        = (state_q == ST_FAULT);
        beat_addr  = {frame_sel, off_q};
        beat_bytes = beat_len;
        bytes_left = rem_q;
        cur_idx    = idx_q;
        cur_off    = off_q;
    end

    // R5
    beat_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> ((PAGE_BITS+1)'(cur_off) + (PAGE_BITS+1)'(beat_bytes)) <= (PAGE_BITS+1)'(PAGE_SIZE));

    // R5
    beat_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_bytes != '0) && (beat_bytes <= BL_W'(BEAT_BYTES)));

    // R6
    page_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |=> (cur_idx == $past(cur_idx)) || (cur_off == '0));

    // R7
    left_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |=> (bytes_left < $past(bytes_left)));

    // R8
    done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bytes_left == '0));

    // R9
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (xfer_len == '0)) |=> done);

    // R10
    idx_in_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (cur_idx < IDX_W'(NUM_PAGES)));

    // R12
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({beat_valid, done, err}));

endmodule

// File: tb/sim_pgx_addr_gen.sv
module sim_pgx_addr_gen;

    localparam int NP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [NP*32-1:0] page_ptrs = '0;
    logic [2:0]  start_idx = '0;
    logic [11:0] start_off = '0;
    logic [15:0] xfer_len = '0;
    logic        beat_valid;
    logic [31:0] beat_addr;
    logic [3:0]  beat_bytes;
    logic [15:0] bytes_left;
    logic [2:0]  cur_idx;
    logic [11:0] cur_off;
    logic        done;
    logic        err;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] ep [NP];

    always #2.5 clk = ~clk;

    pgx_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .page_ptrs(page_ptrs),
        .start_idx(start_idx), .start_off(start_off), .xfer_len(xfer_len),
        .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_bytes(beat_bytes),
        .bytes_left(bytes_left), .cur_idx(cur_idx), .cur_off(cur_off),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_size(input int off, input int rem);
        int s = 8;
        if (rem < s) s = rem;
        if (4096 - off < s) s = 4096 - off;
        return s;
    endfunction

    function automatic bit exp_refuse(input int idx, input int off, input int len);
        if (len == 0) return 1'b0;
        return (idx + ((off + len - 1) >> 12) + 1) > NP;
    endfunction

    task automatic run_xfer(input int idx, input int off, input int len, input bit disturb);
        int m_idx, m_off, m_rem, n, bl;
        logic [31:0] ea;
        for (int k = 0; k < NP; k++) begin
            ep[k] = $urandom;
            page_ptrs[k*32 +: 32] = ep[k];
        end
        @(negedge clk);
        start = 1'b1; start_idx = 3'(idx); start_off = 12'(off); xfer_len = 16'(len);
        @(negedge clk);
        start = 1'b0;
        if (len == 0) begin
            chk(done && !beat_valid && !err, "R9", {61'd0, done, beat_valid, err}, 64'h4);
        end else if (exp_refuse(idx, off, len)) begin
            chk(err && !beat_valid && !done, "R10", {61'd0, done, beat_valid, err}, 64'h1);
        end else begin
            m_idx = idx; m_off = off; m_rem = len; n = 0;
            while (m_rem > 0) begin
                bl = exp_size(m_off, m_rem);
                ea = {ep[m_idx][31:12], 12'(m_off)};
                chk(beat_valid, "R12", {63'd0, beat_valid}, 64'd1);
                if (n == 0)
                    chk(beat_addr == ea, (idx != 0) ? "R11" : "R4", beat_addr, ea);
                else if (m_off == 0)
                    chk(beat_addr == ea, "R6", beat_addr, ea);
                else
                    chk(beat_addr == ea, "R3", beat_addr, ea);
                chk(beat_bytes == 4'(bl), "R5", beat_bytes, bl);
                chk(bytes_left == 16'(m_rem), "R7", bytes_left, m_rem);
                if (disturb && n == 2) begin
                    start = 1'b1;
                    start_idx = 3'($urandom_range(0, 4));
                    start_off = 12'($urandom);
                    xfer_len = 16'($urandom_range(1, 100));
                    page_ptrs = {$urandom, $urandom, $urandom, $urandom, $urandom};
                end
                if (disturb && n == 3) start = 1'b0;
                m_rem -= bl;
                m_off += bl;
                if (m_off == 4096) begin m_off = 0; m_idx++; end
                n++;
                @(negedge clk);
            end
            start = 1'b0;
            chk(done && !beat_valid, "R8", {62'd0, done, beat_valid}, 64'h2);
            chk(cur_idx == 3'(m_idx) && cur_off == 12'(m_off) && bytes_left == 16'd0, "R8",
                {cur_idx, cur_off, bytes_left}, {3'(m_idx), 12'(m_off), 16'd0});
        end
        @(negedge clk);
        chk(!done && !beat_valid && !err, disturb ? "R2" : "R12",
            {61'd0, done, beat_valid, err}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!beat_valid && !done && !err && bytes_left == 0 && cur_idx == 0 && cur_off == 0, "R1",
            {beat_valid, done, err, bytes_left, cur_idx, cur_off}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_valid && !done && !err, "R1", {beat_valid, done, err}, 64'd0);

        run_xfer(0, 0, 0, 1'b0);        // R9 empty request
        run_xfer(0, 4093, 10, 1'b0);    // R5 split at page end, R6 next page at top
        run_xfer(1, 4088, 8, 1'b0);     // R8 ends exactly on page end
        run_xfer(0, 0, 20480, 1'b0);    // R10 exactly five pages accepted
        run_xfer(0, 1, 20480, 1'b0);    // R10 sixth page needed
        run_xfer(4, 0, 4097, 1'b0);     // R10 overflow from last entry
        run_xfer(5, 0, 1, 1'b0);        // R10 start past list
        run_xfer(3, 100, 5000, 1'b0);   // R11 resume mid-list
        run_xfer(0, 7, 300, 1'b1);      // R2 start and pointers disturbed mid-run
        run_xfer(2, 4095, 3, 1'b0);     // R5 one-byte tail of a page

        for (int t = 0; t < 40; t++) begin
            run_xfer($urandom_range(0, 5), $urandom_range(0, 4095),
                     ($urandom_range(0, 3) == 0) ? $urandom_range(0, 20) : $urandom_range(0, 9000),
                     ($urandom_range(0, 7) == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule